// File: doc/BRIEF.md
# Throttle Switch with History Recorder

The block collects sixteen throttle (backpressure) lines and passes them on to two output groups, an L0 group and an L1 group of sixteen lines each. Every channel can take its level from either an optical receiver or an LVDS receiver, and a per-channel select bit makes that choice. A per-channel enable bit masks the channel, so that a disabled channel never asserts throttle on either output group. All receiver inputs go through two-flop synchronisers. The selected levels are then held in a capture register, which updates only while the latch-enable input is high.

Whenever the captured input vector or the forwarded output vector changes, the block writes a snapshot into a derandomizing history FIFO. Each snapshot holds both vectors, a 48-bit free-running cycle timestamp and a 16-bit count of frame pulses. A host drains the FIFO through a 32-bit read port, three words per entry, under the control of a small readout state machine. The host also sees the empty and full flags and a sticky overflow flag. The channel count is fixed at 16 because the first readout word packs both 16-bit vectors. The FIFO depth in entries is a parameter.

Top module: `throttle_switch_recorder`

The readout state machine has three states. READ_LINK presents the vector word and moves to READ_TLO on an accepted strobe. READ_TLO presents the low timestamp word and moves to READ_THI on an accepted strobe. READ_THI presents the high word; on an accepted strobe it pops the entry and returns to READ_LINK. A strobe is accepted only while the FIFO is not empty.

## Requirements
- R1: For channel i, `src_sel[i]`=1 takes the level from `opt_in[i]` and `src_sel[i]`=0 takes it from `lvds_in[i]`.
- R2: A receiver level change appears on the outputs at the third rising edge after it is applied. This holds while `latch_en` is high. While `latch_en` is low the captured vector holds its value. After `latch_en` returns high, the captured vector follows the synchronised levels at the next edge.
- R3: A channel with `in_enable[i]`=0 drives 0 on `l0_out[i]` and on `l1_out[i]`. The two output groups always carry the same vector.
- R4: Exactly one history entry is written for each cycle in which the captured input vector or the output vector changes. A toggle on a masked channel still writes an entry. With no change, nothing is written.
- R5: A 48-bit timestamp advances by one every clock and wraps. The timestamps of two entries differ by the number of cycles between their triggering changes.
- R6: A 16-bit frame counter advances once per cycle with `frame_pulse` high and wraps. Each entry records its value.
- R7: An entry is read as three words. Word 0 is {captured inputs[31:16], outputs[15:0]}. Word 1 is timestamp[31:0]. Word 2 is {frame count[31:16], timestamp[47:32]}. An accepted strobe in the third word pops the entry.
- R8: While the FIFO is empty, `rd_data` is 0 and `rd_strobe` is ignored, so the word sequence does not advance.
- R9: `fifo_empty` and `fifo_full` are never both high. `fifo_full` rises after ENTRIES unread entries and falls after one entry is popped.
- R10: A write while full is dropped and sets `overflow`. The flag stays set until a cycle with `ovf_clr` high.
- R11: After reset, both output groups are 0, `fifo_empty`=1, `fifo_full`=0, `overflow`=0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_in | input | 16 | Optical receiver levels |
| lvds_in | input | 16 | LVDS receiver levels |
| src_sel | input | 16 | Per-channel source select, 1 = optical |
| in_enable | input | 16 | Per-channel enable |
| latch_en | input | 1 | Capture register update enable |
| frame_pulse | input | 1 | Frame counter increment |
| l0_out | output | 16 | L0 throttle outputs |
| l1_out | output | 16 | L1 throttle outputs |
| rd_strobe | input | 1 | Host read strobe, advances one word |
| rd_data | output | 32 | Current readout word |
| fifo_empty | output | 1 | History FIFO empty |
| fifo_full | output | 1 | History FIFO full |
| overflow | output | 1 | Sticky dropped-entry flag |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
The hardest state to reach from the ports is the full FIFO with dropped writes. Reaching it needs ENTRIES distinct change events, each separated so that it produces its own entry, with no read in between. The stimulus toggles one enabled channel every two cycles ENTRIES times, then twice more. The flag state is checked after the first ENTRIES toggles and again after the extra two. A single pop then shows that full clears while overflow stays set, and the drain count shows that the dropped entries never reached storage. Timestamps are checked only as differences between entries, so the checks do not depend on the absolute cycle count since reset.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
    localparam int CH_W    = 16;
    localparam int STAMP_W = 48;
    localparam int FRAME_W = 16;
    localparam int WORD_W  = 32;

    typedef enum logic [1:0] {
        READ_LINK = 2'd0,
        READ_TLO  = 2'd1,
        READ_THI  = 2'd2
    } rd_word_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [STAMP_W-1:0] stamp;
        logic [CH_W-1:0]    ins;
        logic [CH_W-1:0]    outs;
    } hist_entry_t;
endpackage

// File: rtl/tsw_sync.sv
module tsw_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tsw_capture.sv
module tsw_capture
    import tsw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] opt_s,
    input  logic [CH_W-1:0] lvds_s,
    input  logic [CH_W-1:0] src_sel,
    input  logic [CH_W-1:0] in_enable,
    input  logic            latch_en,
    output logic [CH_W-1:0] in_q,
    output logic [CH_W-1:0] out_q,
    output logic            changed
);
    logic [CH_W-1:0] chosen;
    logic [CH_W-1:0] in_nxt;
    logic [CH_W-1:0] out_nxt;

    for (genvar i = 0; i < CH_W; i++) begin : g_chan
        assign chosen[i] = src_sel[i] ? opt_s[i] : lvds_s[i];
    end

    assign in_nxt  = latch_en ? chosen : in_q;
    assign out_nxt = in_nxt & in_enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q    <= '0;
            out_q   <= '0;
            changed <= 1'b0;
        end else begin
            in_q    <= in_nxt;
            out_q   <= out_nxt;
            changed <= (in_nxt != in_q) || (out_nxt != out_q);
        end
    end
endmodule

// File: rtl/tsw_history_fifo.sv
module tsw_history_fifo
    import tsw_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  hist_entry_t wr_entry,
    input  logic        pop,
    input  logic        ovf_clr,
    output hist_entry_t head,
    output logic        empty,
    output logic        full,
    output logic        overflow
);
    localparam int AW = $clog2(ENTRIES);

    hist_entry_t mem [ENTRIES];
    logic [AW:0] wr_ptr;
    logic [AW:0] rd_ptr;
    logic        accept;
    logic        take;

    assign empty  = (wr_ptr == rd_ptr);
    assign full   = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign accept = wr_en && !full;
    assign take   = pop && !empty;
    assign head   = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr[AW-1:0]] <= wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (take)   rd_ptr <= rd_ptr + 1'b1;
            if (wr_en && full) overflow <= 1'b1;
            else if (ovf_clr)  overflow <= 1'b0;
        end
    end
endmodule

// File: rtl/tsw_readout.sv
module tsw_readout
    import tsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              empty,
    input  hist_entry_t       head,
    output logic [WORD_W-1:0] rd_data,
    output logic              pop
);
    rd_word_e state;
    rd_word_e state_nxt;
    logic     advance;

    assign advance = rd_strobe && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= READ_LINK;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            READ_LINK: if (advance) state_nxt = READ_TLO;
            READ_TLO:  if (advance) state_nxt = READ_THI;
            READ_THI:  if (advance) state_nxt = READ_LINK;
            default:   state_nxt = READ_LINK;
        endcase
    end

    always_comb begin
        rd_data = '0;
        pop     = 1'b0;
        if (!empty) begin
            unique case (state)
                READ_LINK: rd_data = {head.ins, head.outs};
                READ_TLO:  rd_data = head.stamp[31:0];
                READ_THI: begin
                    rd_data = {head.frame, head.stamp[STAMP_W-1:32]};
                    pop     = advance;
                end
                default:   rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/throttle_switch_recorder.sv
module throttle_switch_recorder
    import tsw_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   opt_in,
    input  logic [CH_W-1:0]   lvds_in,
    input  logic [CH_W-1:0]   src_sel,
    input  logic [CH_W-1:0]   in_enable,
    input  logic              latch_en,
    input  logic              frame_pulse,
    output logic [CH_W-1:0]   l0_out,
    output logic [CH_W-1:0]   l1_out,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_data,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              overflow,
    input  logic              ovf_clr
);
    logic [CH_W-1:0]    opt_s, lvds_s, in_q, out_q;
    logic               changed, pop;
    logic [STAMP_W-1:0] time_q;
    logic [FRAME_W-1:0] frame_q;
    hist_entry_t        wr_entry, head;

    tsw_sync #(.W(CH_W)) i_sync_opt  (.clk(clk), .rst_n(rst_n), .d(opt_in),  .q(opt_s));
    tsw_sync #(.W(CH_W)) i_sync_lvds (.clk(clk), .rst_n(rst_n), .d(lvds_in), .q(lvds_s));

    tsw_capture i_capture (
        .clk(clk), .rst_n(rst_n), .opt_s(opt_s), .lvds_s(lvds_s),
        .src_sel(src_sel), .in_enable(in_enable), .latch_en(latch_en),
        .in_q(in_q), .out_q(out_q), .changed(changed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q  <= '0;
            frame_q <= '0;
        end else begin
            time_q <= time_q + 1'b1;
            if (frame_pulse) frame_q <= frame_q + 1'b1;
        end
    end

    assign wr_entry = '{frame: frame_q, stamp: time_q, ins: in_q, outs: out_q};

    tsw_history_fifo #(.ENTRIES(ENTRIES)) i_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(changed), .wr_entry(wr_entry),
        .pop(pop), .ovf_clr(ovf_clr), .head(head),
        .empty(fifo_empty), .full(fifo_full), .overflow(overflow)
    );

    tsw_readout i_readout (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .empty(fifo_empty),
        .head(head), .rd_data(rd_data), .pop(pop)
    );

    assign l0_out = out_q;
    assign l1_out = out_q;
endmodule

// File: rtl/tsw_checker.sv
module tsw_checker
    import tsw_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [CH_W-1:0]    l0_out,
    input logic [CH_W-1:0]    in_enable,
    input logic               rd_strobe,
    input logic [WORD_W-1:0]  rd_data,
    input logic               fifo_empty,
    input logic               fifo_full,
    input logic               overflow,
    input logic               ovf_clr,
    input logic [STAMP_W-1:0] stamp
);
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && !rd_strobe |=> fifo_full);

    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l0_out & ~$past(in_enable)) == '0);

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !ovf_clr |=> overflow);

    p_time_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stamp == $past(stamp) + 1'b1);

    p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> rd_data == '0);
endmodule

bind throttle_switch_recorder tsw_checker i_tsw_checker (
    .clk(clk), .rst_n(rst_n), .l0_out(l0_out), .in_enable(in_enable),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .overflow(overflow), .ovf_clr(ovf_clr),
    .stamp(time_q)
);

// File: tb/test_throttle_switch_recorder.sv
module test_throttle_switch_recorder;
    localparam int ENTRIES = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opt_in = '0, lvds_in = '0, src_sel = 16'hFFFF, in_enable = 16'hFFFF;
    logic        latch_en = 1'b1, frame_pulse = 1'b0, rd_strobe = 1'b0, ovf_clr = 1'b0;
    logic [15:0] l0_out, l1_out;
    logic [31:0] rd_data;
    logic        fifo_empty, fifo_full, overflow;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    throttle_switch_recorder #(.ENTRIES(ENTRIES)) i_throttle_switch_recorder (
        .clk(clk), .rst_n(rst_n), .opt_in(opt_in), .lvds_in(lvds_in),
        .src_sel(src_sel), .in_enable(in_enable), .latch_en(latch_en),
        .frame_pulse(frame_pulse), .l0_out(l0_out), .l1_out(l1_out),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .overflow(overflow), .ovf_clr(ovf_clr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_entry(output logic [31:0] w0, output logic [31:0] w1, output logic [31:0] w2);
        logic [31:0] w [3];
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            w[k] = rd_data;
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
        end
        w0 = w[0]; w1 = w[1]; w2 = w[2];
    endtask

    task automatic drain(output int n);
        logic [31:0] a, b, c;
        n = 0;
        while (!fifo_empty) begin
            read_entry(a, b, c);
            n++;
        end
    endtask

    task automatic t_reset;
        chk("R11 l0_out", l0_out, 0);
        chk("R11 l1_out", l1_out, 0);
        chk("R11 empty", fifo_empty, 1);
        chk("R11 full", fifo_full, 0);
        chk("R11 overflow", overflow, 0);
    endtask

    task automatic t_select;
        int n;
        opt_in = 16'h00A5; lvds_in = 16'h5A00; src_sel = 16'hFFFF;
        wait_cyc(6);
        chk("R1 optical", l0_out, 16'h00A5);
        src_sel = 16'h0000;
        wait_cyc(6);
        chk("R1 lvds", l0_out, 16'h5A00);
        src_sel = 16'h00FF;
        wait_cyc(6);
        chk("R1 mixed", l0_out, 16'h5AA5);
        drain(n);
        chk("R4 three changes three entries", n, 3);
        opt_in = '0; lvds_in = '0; src_sel = 16'hFFFF;
        wait_cyc(6);
        drain(n);
    endtask

    task automatic t_latch;
        int n;
        latch_en = 1'b0;
        opt_in = 16'h0003;
        wait_cyc(8);
        chk("R2 held while latch low", l0_out, 16'h0000);
        chk("R4 no entry without change", fifo_empty, 1);
        latch_en = 1'b1;
        wait_cyc(1);
        chk("R2 latch reopen one edge", l0_out, 16'h0003);
        wait_cyc(3);
        opt_in = 16'h0007;
        wait_cyc(2);
        chk("R2 not yet at second edge", l0_out, 16'h0003);
        wait_cyc(1);
        chk("R2 visible at third edge", l0_out, 16'h0007);
        wait_cyc(3);
        drain(n);
        chk("R4 two entries", n, 2);
    endtask

    task automatic t_mask;
        logic [31:0] a, b, c;
        int n;
        in_enable = 16'h0F0F;
        opt_in = 16'hFFFF;
        wait_cyc(6);
        chk("R3 l0 masked", l0_out, 16'h0F0F);
        chk("R3 l1 masked", l1_out, 16'h0F0F);
        read_entry(a, b, c);
        chk("R7 word0 layout", a, 32'hFFFF_0F0F);
        chk("R4 single entry", fifo_empty, 1);
        opt_in = 16'hFFEF;
        wait_cyc(6);
        chk("R3 masked toggle no output", l0_out, 16'h0F0F);
        read_entry(a, b, c);
        chk("R4 masked toggle entry", a, 32'hFFEF_0F0F);
        in_enable = 16'hFFFF;
        opt_in = 16'h0000;
        wait_cyc(6);
        drain(n);
    endtask

    task automatic t_stamp;
        logic [31:0] a0, a1, a2, b0, b1, b2;
        logic [47:0] ta, tb;
        opt_in = 16'h0001;
        wait_cyc(10);
        opt_in = 16'h0000;
        wait_cyc(6);
        read_entry(a0, a1, a2);
        read_entry(b0, b1, b2);
        chk("R7 first entry word0", a0, 32'h0001_0001);
        ta = {a2[15:0], a1};
        tb = {b2[15:0], b1};
        chk("R5 stamp difference", tb - ta, 48'd10);
        chk("R4 exactly two", fifo_empty, 1);
    endtask

    task automatic t_frame;
        logic [31:0] a, b, c;
        for (int k = 0; k < 5; k++) begin
            frame_pulse = 1'b1;
            wait_cyc(1);
            frame_pulse = 1'b0;
            wait_cyc(1);
        end
        opt_in = 16'h0002;
        wait_cyc(6);
        read_entry(a, b, c);
        chk("R6 frame count", c[31:16], 16'd5);
        chk("R7 word0 frame entry", a, 32'h0002_0002);
    endtask

    task automatic t_empty_read;
        logic [31:0] a, b, c;
        for (int k = 0; k < 3; k++) begin
            rd_strobe = 1'b1;
            wait_cyc(1);
            rd_strobe = 1'b0;
            wait_cyc(1);
        end
        chk("R8 rd_data zero when empty", rd_data, 0);
        opt_in = 16'h0004;
        wait_cyc(6);
        read_entry(a, b, c);
        chk("R8 sequence not advanced", a, 32'h0004_0004);
        chk("R8 frame word intact", c[31:16], 16'd5);
    endtask

    task automatic t_full;
        logic [31:0] a, b, c;
        int n;
        for (int k = 0; k < ENTRIES; k++) begin
            opt_in[0] = ~opt_in[0];
            wait_cyc(2);
        end
        wait_cyc(6);
        chk("R9 full at capacity", fifo_full, 1);
        chk("R9 not empty", fifo_empty, 0);
        chk("R10 no overflow yet", overflow, 0);
        for (int k = 0; k < 2; k++) begin
            opt_in[0] = ~opt_in[0];
            wait_cyc(2);
        end
        wait_cyc(6);
        chk("R10 overflow set", overflow, 1);
        read_entry(a, b, c);
        chk("R10 oldest kept", a, 32'h0005_0005);
        chk("R9 full clears after pop", fifo_full, 0);
        chk("R10 overflow sticky", overflow, 1);
        ovf_clr = 1'b1;
        wait_cyc(1);
        ovf_clr = 1'b0;
        wait_cyc(1);
        chk("R10 overflow cleared", overflow, 0);
        drain(n);
        chk("R10 dropped entries absent", n, ENTRIES - 1);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_select();
        t_latch();
        t_mask();
        t_stamp();
        t_frame();
        t_empty_read();
        t_full();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule